// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host bus and the embedded-operation engine of an x16 NOR-style flash. It watches every accepted host write, matches the address/data pairs of the multi-cycle unlock sequences, and issues one-cycle start pulses to the engine. Each pulse comes with a target address and, for a program, the data word. The recognised commands are: word program, sector erase, chip erase, identification-mode entry, return to read-array, and sector lockdown.

The decoder keeps one lock bit per erase sector. There are 39 sectors: thirty-one of 32K words and eight of 4K words. The eight small sectors sit at the bottom or the top of the array, depending on a boot-configuration input. A program or erase aimed at a locked sector produces a reject pulse in place of a start pulse. Only reset clears a lock bit. While the engine reports busy, host writes are ignored completely.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After the active-low synchronous reset, the block is in read-array mode, identification mode is off, every start pulse and the reject flag are low, and no sector is locked.
- R2: Command cycles match on the low 12 address bits and the low 8 data bits. A word program is four writes: AA@555, 55@AAA, A0@555, then the data at the target address. In the cycle after the fourth write, `prog_go` pulses for one cycle, with `op_addr` set to the target and `op_data` set to the full data word.
- R3: A sector erase is six writes: AA@555, 55@AAA, 80@555, AA@555, 55@AAA, then 30 at any address inside the sector. `sect_erase_go` pulses in the cycle after the last write, with `op_addr` equal to that address.
- R4: A chip erase is the same five-write prefix followed by 10@555. It pulses `chip_erase_go` with `op_addr` zero, or pulses `lock_reject` instead if any sector is locked.
- R5: AA@555, 55@AAA, 90@555 sets `id_mode`. A write of F0 (not the program data cycle) at any address clears it and returns the block to read-array, alone or after AA@555, 55@AAA.
- R6: A write whose address or data breaks the expected sequence returns the block to read-array and issues nothing, so the remaining cycles of that sequence produce no pulse.
- R7: While `busy` is high, writes have no effect: no pulse, no change of mode, and the partial sequence already received is kept.
- R8: The prefix AA@555, 55@AAA, 80@555, AA@555, 55@AAA followed by 60 at a sector address locks that sector. A later program or sector erase inside a locked sector pulses `lock_reject` for one cycle and no start pulse.
- R9: With `boot_top`=0, sectors 0–7 are the 4K-word blocks at addresses 0x00000–0x07FFF and sectors 8–38 are the 32K-word blocks above them. With `boot_top`=1, sectors 0–30 are the 32K-word blocks from 0x00000 and sectors 31–38 are the 4K-word blocks from 0xF8000.
- R10: A lock set before reset no longer blocks program or erase after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per bus write |
| wr_addr | input | 20 | Word address of the write |
| wr_data | input | 16 | Data of the write |
| boot_top | input | 1 | Small sectors at top (1) or bottom (0) |
| busy | input | 1 | Engine is running a program or erase |
| prog_go | output | 1 | Word program start pulse |
| sect_erase_go | output | 1 | Sector erase start pulse |
| chip_erase_go | output | 1 | Chip erase start pulse |
| lock_reject | output | 1 | Request hit a locked sector |
| op_addr | output | 20 | Target address for the engine |
| op_data | output | 16 | Program data for the engine |
| id_mode | output | 1 | Identification mode active |

## Verification
A wrong sequence state shows up one cycle after the final write of a command. The symptom is a missing pulse, an unexpected pulse, or a wrong `op_addr`. A corrupted lock bit stays hidden until a program or erase reaches that sector. For that reason, random operations are scattered over sectors after random locks, across both boot layouts. Busy handling is checked by resuming a sequence after the busy window ends.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int BIG_W   = 15,
  parameter int SMALL_W = 12,
  parameter int CMD_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              boot_top,
  input  logic              busy,
  output logic              prog_go,
  output logic              sect_erase_go,
  output logic              chip_erase_go,
  output logic              lock_reject,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              id_mode
);
  localparam int NUM_BIG   = (1 << (ADDR_W - BIG_W)) - 1;
  localparam int NUM_SMALL = 1 << (BIG_W - SMALL_W);
  localparam int NSECT     = NUM_BIG + NUM_SMALL;
  localparam int SECT_W    = $clog2(NSECT);
  localparam int BLK_W     = ADDR_W - BIG_W;
  localparam int SUB_W     = BIG_W - SMALL_W;
  localparam logic [CMD_W-1:0] ADR_A = CMD_W'(12'h555);
  localparam logic [CMD_W-1:0] ADR_B = CMD_W'(12'hAAA);

  typedef enum logic [2:0] {S_IDLE, S_UL1, S_UL2, S_PROG, S_ER1, S_ER2, S_ER3} state_t;

  state_t           state;
  logic [NSECT-1:0] locks;
  logic [SECT_W-1:0] sect;

  wire [BLK_W-1:0] blk = wr_addr[ADDR_W-1:BIG_W];
  wire [SUB_W-1:0] sub = wr_addr[BIG_W-1:SMALL_W];
  wire [7:0]       cmd = wr_data[7:0];
  wire             at_a = wr_addr[CMD_W-1:0] == ADR_A;
  wire             at_b = wr_addr[CMD_W-1:0] == ADR_B;
  wire             take = wr_en && !busy;
  wire             sect_locked = locks[sect];

  always_comb begin
    if (boot_top)
      sect = (blk == '1) ? SECT_W'(NUM_BIG) + SECT_W'(sub) : SECT_W'(blk);
    else
      sect = (blk == '0) ? SECT_W'(sub) : SECT_W'(NUM_SMALL - 1) + SECT_W'(blk);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      locks         <= '0;
      id_mode       <= 1'b0;
      prog_go       <= 1'b0;
      sect_erase_go <= 1'b0;
      chip_erase_go <= 1'b0;
      lock_reject   <= 1'b0;
      op_addr       <= '0;
      op_data       <= '0;
    end else begin
      prog_go       <= 1'b0;
      sect_erase_go <= 1'b0;
      chip_erase_go <= 1'b0;
      lock_reject   <= 1'b0;
      if (take) begin
        if (cmd == 8'hF0 && state != S_PROG) begin
          state   <= S_IDLE;
          id_mode <= 1'b0;
        end else begin
          state <= S_IDLE;
          case (state)
            S_IDLE: if (at_a && cmd == 8'hAA) state <= S_UL1;
            S_UL1:  if (at_b && cmd == 8'h55) state <= S_UL2;
            S_UL2:
              if (at_a) begin
                case (cmd)
                  8'hA0:   state <= S_PROG;
                  8'h80:   state <= S_ER1;
                  8'h90:   id_mode <= 1'b1;
                  default: state <= S_IDLE;
                endcase
              end
            S_PROG:
              if (sect_locked) lock_reject <= 1'b1;
              else begin
                prog_go <= 1'b1;
                op_addr <= wr_addr;
                op_data <= wr_data;
              end
            S_ER1: if (at_a && cmd == 8'hAA) state <= S_ER2;
            S_ER2: if (at_b && cmd == 8'h55) state <= S_ER3;
            S_ER3:
              if (cmd == 8'h10 && at_a) begin
                if (|locks) lock_reject <= 1'b1;
                else begin
                  chip_erase_go <= 1'b1;
                  op_addr       <= '0;
                end
              end else if (cmd == 8'h30) begin
                if (sect_locked) lock_reject <= 1'b1;
                else begin
                  sect_erase_go <= 1'b1;
                  op_addr       <= wr_addr;
                end
              end else if (cmd == 8'h60) begin
                locks[sect] <= 1'b1;
              end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       busy,
  input logic [7:0] wr_cmd,
  input logic       prog_go,
  input logic       sect_erase_go,
  input logic       chip_erase_go,
  input logic       lock_reject,
  input logic       id_mode
);
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_go, sect_erase_go, chip_erase_go, lock_reject}));

  a_r7_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> !(prog_go || sect_erase_go || chip_erase_go || lock_reject));

  a_r7_busy_keeps_id: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> $stable(id_mode));

  a_r2_prog_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || busy) |=> !prog_go);

  a_r5_id_on_90: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_mode ##1 id_mode) |-> $past(wr_en && !busy && wr_cmd == 8'h90));

  a_r5_id_off_f0: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode ##1 !id_mode) |-> $past(wr_en && !busy && wr_cmd == 8'hF0));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy), .wr_cmd(wr_data[7:0]),
  .prog_go(prog_go), .sect_erase_go(sect_erase_go), .chip_erase_go(chip_erase_go),
  .lock_reject(lock_reject), .id_mode(id_mode)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        boot_top = 1'b0;
  logic        busy = 1'b0;
  logic        prog_go, sect_erase_go, chip_erase_go, lock_reject, id_mode;
  logic [19:0] op_addr;
  logic [15:0] op_data;

  int  n_run = 0, n_fail = 0;
  bit  lk[39];
  logic c_prog, c_se, c_ce, c_rej;
  logic [19:0] c_addr;
  logic [15:0] c_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .boot_top(boot_top), .busy(busy), .prog_go(prog_go), .sect_erase_go(sect_erase_go),
    .chip_erase_go(chip_erase_go), .lock_reject(lock_reject), .op_addr(op_addr),
    .op_data(op_data), .id_mode(id_mode)
  );

  function automatic int sector_of(logic [19:0] a, logic top);
    int blk = int'(a[19:15]);
    int sub = int'(a[14:12]);
    if (top) return (blk == 31) ? 31 + sub : blk;
    return (blk == 0) ? sub : 7 + blk;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [19:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    c_prog = prog_go; c_se = sect_erase_go; c_ce = chip_erase_go; c_rej = lock_reject;
    c_addr = op_addr; c_data = op_data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock(); wr(20'h00555, 16'hAA); wr(20'h00AAA, 16'h55); endtask
  task automatic do_prog(logic [19:0] a, logic [15:0] d);
    unlock(); wr(20'h00555, 16'hA0); wr(a, d);
  endtask
  task automatic erase_pre(); unlock(); wr(20'h00555, 16'h80); unlock(); endtask
  task automatic do_serase(logic [19:0] a); erase_pre(); wr(a, 16'h30); endtask
  task automatic do_lock(logic [19:0] a);
    erase_pre(); wr(a, 16'h60); lk[sector_of(a, boot_top)] = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    foreach (lk[i]) lk[i] = 1'b0;
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    foreach (lk[i]) lk[i] = 1'b0;
    repeat (3) @(negedge clk);
    check({prog_go, sect_erase_go, chip_erase_go, lock_reject, id_mode} == 5'b0, "R1 reset outputs",
          {prog_go, sect_erase_go, chip_erase_go, lock_reject, id_mode}, 0);
    rst_n = 1'b1;

    do_prog(20'h12345, 16'hBEEF);
    check(c_prog && !c_rej, "R2 program pulse", c_prog, 1);
    check(c_addr == 20'h12345 && c_data == 16'hBEEF, "R2 program addr/data", {c_addr, c_data}, 36'h12345BEEF);
    @(posedge clk); #1;
    check(!prog_go, "R2 single-cycle pulse", prog_go, 0);

    do_serase(20'h4A000);
    check(c_se && c_addr == 20'h4A000, "R3 sector erase", {c_se, c_addr}, {1'b1, 20'h4A000});

    erase_pre(); wr(20'h00555, 16'h10);
    check(c_ce && c_addr == 0, "R4 chip erase", {c_ce, c_addr}, {1'b1, 20'h0});

    unlock(); wr(20'h00555, 16'h90);
    check(id_mode == 1'b1, "R5 id entry", id_mode, 1);
    wr(20'h7777, 16'hF0);
    check(id_mode == 1'b0, "R5 F0 exit", id_mode, 0);
    unlock(); wr(20'h00555, 16'h90); unlock(); wr(20'h00555, 16'hF0);
    check(id_mode == 1'b0, "R5 three-cycle exit", id_mode, 0);

    wr(20'h00555, 16'hAA); wr(20'h00555, 16'h55); wr(20'h00555, 16'hA0); wr(20'h01000, 16'h1234);
    check(!c_prog && !c_rej, "R6 wrong address aborts", c_prog, 0);
    unlock(); wr(20'h00555, 16'h80); wr(20'h00555, 16'hAB); unlock(); wr(20'h20000, 16'h30);
    check(!c_se, "R6 wrong data aborts", c_se, 0);

    unlock();
    busy = 1'b1;
    wr(20'h00555, 16'h90);
    check(id_mode == 1'b0 && !c_prog, "R7 busy write ignored", id_mode, 0);
    wr(20'h00000, 16'hF0);
    busy = 1'b0;
    wr(20'h00555, 16'hA0); wr(20'h33333, 16'h00FF);
    check(c_prog && c_addr == 20'h33333, "R7 sequence kept across busy", c_prog, 1);

    boot_top = 1'b0;
    do_lock(20'h01000);
    do_prog(20'h01FFF, 16'h0);
    check(c_rej && !c_prog, "R8 locked program rejected", {c_rej, c_prog}, 2'b10);
    @(posedge clk); #1;
    check(!lock_reject, "R8 reject one cycle", lock_reject, 0);
    do_prog(20'h02000, 16'h0);
    check(c_prog && !c_rej, "R9 bottom small sectors separate", c_prog, 1);
    erase_pre(); wr(20'h00555, 16'h10);
    check(c_rej && !c_ce, "R4 chip erase blocked by lock", {c_rej, c_ce}, 2'b10);

    do_reset();
    do_prog(20'h01000, 16'h5555);
    check(c_prog && !c_rej, "R10 reset clears lock", c_prog, 1);

    boot_top = 1'b1;
    do_lock(20'h01000);
    do_serase(20'h07FFF);
    check(c_rej, "R9 top boot: low 32K one sector", c_rej, 1);
    do_lock(20'hF9000);
    do_serase(20'hFA000);
    check(c_se && !c_rej, "R9 top small sectors separate", c_se, 1);
    do_serase(20'hF9ABC);
    check(c_rej, "R9 top small sector locked", c_rej, 1);

    for (int round = 0; round < 2; round++) begin
      do_reset();
      boot_top = round[0];
      for (int k = 0; k < 4; k++) do_lock(20'($urandom));
      for (int k = 0; k < 40; k++) begin
        logic [19:0] a = 20'($urandom);
        logic [15:0] d = 16'($urandom);
        bit exp_rej = lk[sector_of(a, boot_top)];
        if ($urandom % 2 == 0) begin
          do_prog(a, d);
          check(c_rej == exp_rej && c_prog == !exp_rej && (exp_rej || (c_addr == a && c_data == d)),
                "R8 random program", {c_rej, c_prog}, {exp_rej, !exp_rej});
        end else begin
          do_serase(a);
          check(c_rej == exp_rej && c_se == !exp_rej && (exp_rej || c_addr == a),
                "R3 random sector erase", {c_rej, c_se}, {exp_rej, !exp_rej});
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule